// File: doc/BRIEF.md
# Keyboard Controller Output Port and A20 Gate

This block keeps the 8-bit output port of a PC-style keyboard controller. It drives two system lines from it: the A20 address gate, taken from bit 1, and an active-low system reset pulse. The host changes the port in three ways. It can issue command 0xD1 and then write a full byte to the data port. It can use the dedicated gate commands 0xDF and 0xDD. It can use the pulse command family 0xF0 to 0xFF, where only bit 0 of the command matters and a zero in that bit requests a CPU reset.

Bits 4 and 5 of the port are not written by the host. They follow the keyboard and auxiliary output-full flags, which come from the neighbouring buffer logic. They therefore drop as soon as that logic sees the host read the output byte. Command 0xD0 returns the port value as a one-cycle reply. The length of the reset pulse is set by the clock frequency and a pulse width in microseconds. The nominal width is about 6 µs.

Top module: `kbc_outport`

## Requirements
- R1: After reset the port reads 0xCF (bits 0, 1, 2, 3, 6, 7 set; bits 4, 5 clear with both flags low), a20_gate is 1, sys_reset_n is 1 and reply_valid is 0.
- R2: Command 0xD1 arms a full write. The next data write stores all port bits except 4 and 5, one clock after the strobe, and a20_gate then equals the new bit 1.
- R3: A data write with no armed 0xD1 leaves the port unchanged. Commands 0x60, 0xD2, 0xD3 and 0xD4 disarm a pending 0xD1. One data write consumes the arming.
- R4: Command 0xDF sets port bit 1 and a20_gate. Command 0xDD clears both. Either takes effect one clock after the strobe.
- R5: A command with upper nibble 0xF requests a reset pulse when its bit 0 is 0 and does nothing when its bit 0 is 1. In both cases port bits 0-3, 6 and 7 are unchanged.
- R6: A full write (R2) with bit 0 equal to 0 starts a reset pulse one clock after the data strobe.
- R7: A reset pulse holds sys_reset_n low for exactly CLK_MHZ*PULSE_US cycles (600 by default). A new request while a pulse is running is ignored.
- R8: Port bit 4 equals kbd_obf and bit 5 equals aux_obf, each as sampled on the previous clock.
- R9: Command 0xD0 raises reply_valid for one cycle, one clock later. reply_byte then equals the port value, including the flag bits present in the command cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_we | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Command byte |
| dat_we | input | 1 | Data byte strobe (ignored in a cycle with cmd_we) |
| dat_byte | input | 8 | Data byte |
| kbd_obf | input | 1 | Keyboard output-full flag |
| aux_obf | input | 1 | Auxiliary output-full flag |
| port_q | output | 8 | Current output port value |
| a20_gate | output | 1 | A20 gate line |
| sys_reset_n | output | 1 | Active-low system reset pulse |
| reply_valid | output | 1 | One-cycle strobe for the 0xD0 reply |
| reply_byte | output | 8 | Reply byte for 0xD0 |

## Verification
The bench aims at the arming of 0xD1. A design that kept the arming after a competing 0x60 command, or after one data byte, would overwrite the port with a later keyboard byte and could pull the gate or reset. It writes the flag bits with values that differ from the flags. A design that stored them would show stale output-full bits until the next flag change. It sends pulse commands with both values of bit 0 and full writes with bit 0 clear. A wrong remap would either reset the system on a harmless 0xFF or 0xF1, or miss the reset on 0xF0. It measures the pulse length and retriggers in the middle of a pulse. An off-by-one counter or a restart on retrigger shows up as a wrong low count.

// File: rtl/kbc_outport_pkg.sv
package kbc_outport_pkg;

    localparam int PORT_W  = 8;
    localparam int KBD_BIT = 4;
    localparam int AUX_BIT = 5;
    localparam int A20_BIT = 1;
    localparam int RUN_BIT = 0;

    localparam logic [PORT_W-1:0] PORT_RESET  = 8'hCF;
    localparam logic [PORT_W-1:0] MIRROR_MASK = (PORT_W'(1) << KBD_BIT) | (PORT_W'(1) << AUX_BIT);

    typedef enum logic [2:0] {
        OP_NONE,
        OP_ARM_PORT,
        OP_ARM_OTHER,
        OP_GATE_ON,
        OP_GATE_OFF,
        OP_PULSE_RST,
        OP_READ
    } op_e;

    typedef struct packed {
        logic [PORT_W-1:0] port;
        logic              arm;
        logic              reply_v;
        logic [PORT_W-1:0] reply_b;
    } ctl_s;

endpackage

// File: rtl/kbc_outport_decode.sv
module kbc_outport_decode
    import kbc_outport_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output op_e        op
);
    always_comb begin
        op = OP_NONE;
        if (cmd_byte[7:4] == 4'hF) begin
            // pulse family: only bit 0 selects reset vs no-op
            op = cmd_byte[0] ? OP_NONE : OP_PULSE_RST;
        end else begin
            case (cmd_byte)
                8'hD1:                      op = OP_ARM_PORT;
                8'h60, 8'hD2, 8'hD3, 8'hD4: op = OP_ARM_OTHER;
                8'hDF:                      op = OP_GATE_ON;
                8'hDD:                      op = OP_GATE_OFF;
                8'hD0:                      op = OP_READ;
                default:                    op = OP_NONE;
            endcase
        end
    end
endmodule

// File: rtl/kbc_outport_pulse.sv
module kbc_outport_pulse #(
    parameter int PULSE_CYCLES = 600
) (
    input  logic clk,
    input  logic rst_n,
    input  logic trig,
    output logic pulse_n
);
    localparam int CNT_W = $clog2(PULSE_CYCLES + 1);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (cnt_q != '0) begin
            cnt_d = cnt_q - CNT_W'(1);
        end else if (trig) begin
            cnt_d = CNT_W'(PULSE_CYCLES);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign pulse_n = (cnt_q == '0);
endmodule

// File: rtl/kbc_outport.sv
module kbc_outport
    import kbc_outport_pkg::*;
#(
    parameter int CLK_MHZ  = 100,
    parameter int PULSE_US = 6
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_we,
    input  logic [7:0] cmd_byte,
    input  logic       dat_we,
    input  logic [7:0] dat_byte,
    input  logic       kbd_obf,
    input  logic       aux_obf,
    output logic [7:0] port_q,
    output logic       a20_gate,
    output logic       sys_reset_n,
    output logic       reply_valid,
    output logic [7:0] reply_byte
);
    localparam int PULSE_CYCLES = CLK_MHZ * PULSE_US;

    op_e   op;
    ctl_s  st_d, st_q;
    logic  trig_d;

    kbc_outport_decode i_decode (
        .cmd_byte (cmd_byte),
        .op       (op)
    );

    always_comb begin
        logic [PORT_W-1:0] base;
        logic [PORT_W-1:0] flags;
        st_d         = st_q;
        st_d.reply_v = 1'b0;
        trig_d       = 1'b0;
        base         = st_q.port;

        if (cmd_we) begin
            case (op)
                OP_ARM_PORT:  st_d.arm = 1'b1;
                OP_ARM_OTHER: st_d.arm = 1'b0;
                OP_GATE_ON:   base[A20_BIT] = 1'b1;
                OP_GATE_OFF:  base[A20_BIT] = 1'b0;
                OP_PULSE_RST: trig_d = 1'b1;
                OP_READ:      st_d.reply_v = 1'b1;
                default:      ;
            endcase
        end else if (dat_we && st_q.arm) begin
            base     = dat_byte;
            st_d.arm = 1'b0;
            trig_d   = ~dat_byte[RUN_BIT];
        end

        flags = '0;
        flags[KBD_BIT] = kbd_obf;
        flags[AUX_BIT] = aux_obf;
        st_d.port = (base & ~MIRROR_MASK) | flags;

        if (st_d.reply_v) begin
            st_d.reply_b = st_d.port;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.port    <= PORT_RESET;
            st_q.arm     <= 1'b0;
            st_q.reply_v <= 1'b0;
            st_q.reply_b <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    kbc_outport_pulse #(
        .PULSE_CYCLES (PULSE_CYCLES)
    ) i_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trig    (trig_d),
        .pulse_n (sys_reset_n)
    );

    assign port_q      = st_q.port;
    assign a20_gate    = st_q.port[A20_BIT];
    assign reply_valid = st_q.reply_v;
    assign reply_byte  = st_q.reply_b;
endmodule

// File: rtl/kbc_outport_chk.sv
module kbc_outport_chk #(
    parameter int PULSE_CYCLES = 600
) (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_we,
    input logic [7:0] cmd_byte,
    input logic       dat_we,
    input logic       kbd_obf,
    input logic       aux_obf,
    input logic [7:0] port_q,
    input logic       a20_gate,
    input logic       sys_reset_n,
    input logic       reply_valid,
    input logic [7:0] reply_byte
);
    localparam int LW = $clog2(PULSE_CYCLES + 2);
    logic [LW-1:0] low_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            low_q <= '0;
        else if (!sys_reset_n) low_q <= low_q + LW'(1);
        else                   low_q <= '0;
    end

    assert_gate_on_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hDF) |=> a20_gate);
    assert_gate_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte == 8'hDD) |=> !a20_gate);
    assert_mirror_kbd_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> port_q[4] == $past(kbd_obf));
    assert_mirror_aux_R8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> port_q[5] == $past(aux_obf));
    assert_reply_match_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid |-> reply_byte == port_q);
    assert_reply_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        reply_valid |-> $past(cmd_we && cmd_byte == 8'hD0));
    assert_pulse_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:4] == 4'hF && !cmd_byte[0] && sys_reset_n) |=> !sys_reset_n);
    assert_pulse_keep_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_byte[7:4] == 4'hF)
        |=> {port_q[7:6], port_q[3:0]} == $past({port_q[7:6], port_q[3:0]}));
    assert_pulse_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sys_reset_n) |-> $past(cmd_we || dat_we));
    assert_pulse_width_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sys_reset_n) |-> low_q == LW'(PULSE_CYCLES));
endmodule

bind kbc_outport kbc_outport_chk #(.PULSE_CYCLES(PULSE_CYCLES)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_we      (cmd_we),
    .cmd_byte    (cmd_byte),
    .dat_we      (dat_we),
    .kbd_obf     (kbd_obf),
    .aux_obf     (aux_obf),
    .port_q      (port_q),
    .a20_gate    (a20_gate),
    .sys_reset_n (sys_reset_n),
    .reply_valid (reply_valid),
    .reply_byte  (reply_byte)
);

// File: tb/test_kbc_outport.sv
module test_kbc_outport;
    localparam int PULSE = 600;
    localparam int NV    = 16;
    // {is_data, byte, kbd, aux, exp_port, exp_a20}
    localparam logic [19:0] VEC [NV] = '{
        {1'b0, 8'hDD, 1'b0, 1'b0, 8'hCD, 1'b0},  // R4 off
        {1'b0, 8'hDF, 1'b0, 1'b0, 8'hCF, 1'b1},  // R4 on
        {1'b0, 8'hD1, 1'b0, 1'b0, 8'hCF, 1'b1},  // R2 arm
        {1'b1, 8'h03, 1'b1, 1'b0, 8'h13, 1'b1},  // R2 write, R8 kbd
        {1'b0, 8'hD1, 1'b0, 1'b1, 8'h23, 1'b1},  // R8 aux
        {1'b1, 8'hF1, 1'b0, 1'b1, 8'hE1, 1'b0},  // R2 bits 4/5 not stored
        {1'b1, 8'h00, 1'b0, 1'b0, 8'hC1, 1'b0},  // R3 unarmed data
        {1'b0, 8'hDF, 1'b0, 1'b0, 8'hC3, 1'b1},  // R4
        {1'b0, 8'hFF, 1'b0, 1'b0, 8'hC3, 1'b1},  // R5 no-op
        {1'b0, 8'hF1, 1'b0, 1'b0, 8'hC3, 1'b1},  // R5 no-op
        {1'b0, 8'hD1, 1'b0, 1'b0, 8'hC3, 1'b1},  // R3 arm
        {1'b0, 8'h60, 1'b0, 1'b0, 8'hC3, 1'b1},  // R3 disarm
        {1'b1, 8'h00, 1'b0, 1'b0, 8'hC3, 1'b1},  // R3 ignored
        {1'b0, 8'hDD, 1'b1, 1'b1, 8'hF1, 1'b0},  // R4, R8 both
        {1'b0, 8'hD1, 1'b0, 1'b0, 8'hC1, 1'b0},  // R2 arm
        {1'b1, 8'hCF, 1'b0, 1'b0, 8'hCF, 1'b1}   // R2 restore
    };

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_we = 1'b0;
    logic [7:0] cmd_byte = '0;
    logic       dat_we = 1'b0;
    logic [7:0] dat_byte = '0;
    logic       kbd_obf = 1'b0;
    logic       aux_obf = 1'b0;
    logic [7:0] port_q;
    logic       a20_gate;
    logic       sys_reset_n;
    logic       reply_valid;
    logic [7:0] reply_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    kbc_outport i_kbc_outport (
        .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_byte(cmd_byte),
        .dat_we(dat_we), .dat_byte(dat_byte), .kbd_obf(kbd_obf), .aux_obf(aux_obf),
        .port_q(port_q), .a20_gate(a20_gate), .sys_reset_n(sys_reset_n),
        .reply_valid(reply_valid), .reply_byte(reply_byte)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic do_op(input logic is_data, input logic [7:0] b);
        @(negedge clk);
        if (is_data) begin dat_we = 1'b1; dat_byte = b; end
        else         begin cmd_we = 1'b1; cmd_byte = b; end
        @(negedge clk);
        cmd_we = 1'b0;
        dat_we = 1'b0;
    endtask

    // called right after the triggering op; counts low cycles, optional retrigger
    task automatic measure(input string req, input bit retrig);
        int n = 0;
        while (!sys_reset_n && n < 5000) begin
            if (retrig && n == 100) begin cmd_we = 1'b1; cmd_byte = 8'hFE; end
            else cmd_we = 1'b0;
            n++;
            @(negedge clk);
        end
        cmd_we = 1'b0;
        check(req, n, PULSE);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 port", port_q, 8'hCF);
        check("R1 a20", a20_gate, 1'b1);
        check("R1 rst", sys_reset_n, 1'b1);
        check("R1 reply", reply_valid, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 port after release", port_q, 8'hCF);

        for (int i = 0; i < NV; i++) begin
            kbd_obf = VEC[i][10];
            aux_obf = VEC[i][9];
            do_op(VEC[i][19], VEC[i][18:11]);
            check($sformatf("R2/R3/R4/R5/R8 vec%0d port", i), port_q, VEC[i][8:1]);
            check($sformatf("R2/R4 vec%0d a20", i), a20_gate, VEC[i][0]);
            check($sformatf("R5 vec%0d no reset", i), sys_reset_n, 1'b1);
            check($sformatf("R9 vec%0d no reply", i), reply_valid, 1'b0);
        end

        // R9 read-back with flags present in command cycle
        kbd_obf = 1'b1; aux_obf = 1'b0;
        do_op(1'b0, 8'hD0);
        check("R9 valid", reply_valid, 1'b1);
        check("R9 byte kbd", reply_byte, 8'hDF);
        @(negedge clk);
        check("R9 single cycle", reply_valid, 1'b0);
        kbd_obf = 1'b1; aux_obf = 1'b1;
        do_op(1'b0, 8'hD0);
        check("R9 byte both", reply_byte, 8'hFF);
        kbd_obf = 1'b0; aux_obf = 1'b0;
        @(negedge clk);
        check("R8 flags cleared", port_q, 8'hCF);

        // R5 pulse command 0xFE
        do_op(1'b0, 8'hFE);
        check("R5 FE starts pulse", sys_reset_n, 1'b0);
        check("R5 FE port kept", port_q, 8'hCF);
        measure("R7 width FE", 1'b0);
        // R5 pulse command 0xF0
        do_op(1'b0, 8'hF0);
        check("R5 F0 starts pulse", sys_reset_n, 1'b0);
        measure("R7 width F0", 1'b0);
        // R6 full write with bit 0 clear
        do_op(1'b0, 8'hD1);
        do_op(1'b1, 8'hCE);
        check("R6 pulse", sys_reset_n, 1'b0);
        check("R6 port", port_q, 8'hCE);
        check("R6 a20", a20_gate, 1'b1);
        measure("R7 width write", 1'b0);
        // R7 retrigger ignored
        do_op(1'b0, 8'hFE);
        measure("R7 retrigger ignored", 1'b1);
        repeat (3) @(negedge clk);
        check("R7 stays high after pulse", sys_reset_n, 1'b1);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #500000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule